// File: doc/BRIEF.md
# UART Receiver with Two-Entry Character Queue

This block is the receive half of a UART host interface. A 16x oversampling tick from outside drives a small state machine. The machine looks for a start bit on the serial input, confirms it at mid-bit and shifts in 5 to 8 data bits, least significant bit first. It then samples the first stop bit. Each finished character passes through a one-character holding stage and goes into a two-entry queue. The queue keeps the framing status of each character next to its data.

The host uses a small register bus with three addresses. Reading the data address returns the character at the head of the queue and removes it. The status address shows whether data is waiting, whether the head character had a bad stop bit, and whether an overrun was seen. The control address turns the receiver on, unmasks the interrupt and selects the character length. Turning the receiver off empties the queue and drops the held character.

The receive state machine has four states. IDLE goes to START_CHECK on a tick that sees the line low. START_CHECK goes back to IDLE if the line is high at the mid-bit tick, and goes to SHIFT_DATA if it is low. SHIFT_DATA goes to STOP_CHECK after the last data bit is sampled. STOP_CHECK goes to IDLE at the stop bit's mid-point, and on that tick it hands the character on. Clearing the enable forces IDLE from any state.

Top module: `uart_rx_fifo_top`

## Requirements
- R1: After reset, the status register (address 1) reads 0x00, the control register (address 2) reads 0x00 and irq is 0.
- R2: A start bit is accepted only when the line is low on the 8th tick after the first low tick. Each data bit (LSB first) and the stop bit are then sampled every 16 ticks. The received character becomes readable at address 0, and status bit 7 is 1 while the queue holds unread data and 0 when the queue is empty.
- R3: Each read of address 0 removes the head character. Two characters received back to back are returned in arrival order.
- R4: Control bits [3:2] set the character length: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. Data bits above the chosen length read as zero.
- R5: Status bit 4 is 1 when the head character's stop bit was sampled low and 0 when it was sampled high. It follows each character as that character reaches the head.
- R6: Suppose the queue holds two characters and a third is waiting in the holding stage. If a new start bit is then confirmed, status bit 3 becomes 1, the held character is discarded and the two queued characters are kept. Bit 3 returns to 0 at the next read of address 0.
- R7: Host writes to address 1 do not change status bits 4 or 3.
- R8: A low pulse on the line that is shorter than 8 ticks produces no character.
- R9: Clearing control bit 0 (receiver enable) empties the queue and drops the held character, so status reads 0x00. While the enable is 0, line activity produces no character.
- R10: irq is status bit 7 ANDed with control bit 1 (interrupt enable).
- R11: A third character held while the queue is full moves into the queue when the head is read, provided no new start bit was confirmed before that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | 0 data, 1 status, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with its defaults: 16 ticks per bit, mid-bit sampling on tick 8, a queue depth of two and up to 8 data bits. The bench asserts a tick every second clock, so one bit lasts 32 clocks. That keeps a whole frame near 350 clocks, which makes the overrun case affordable: it needs four frames back to back. A bench stop bit that is low for only ten ticks both raises a framing error and starts a false start that must be rejected. All four character lengths are reached through the control register.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START_CHECK,
        RX_SHIFT_DATA,
        RX_STOP_CHECK
    } rx_state_e;

    localparam logic [1:0] ADDR_DATA   = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    localparam int STAT_READY_BIT = 7;
    localparam int STAT_FERR_BIT  = 4;
    localparam int STAT_OVR_BIT   = 3;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_IE_BIT    = 1;
    localparam int CTRL_SIZE_LO   = 2;

    localparam int BUS_W = 8;

endpackage

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
    import uart_rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int SAMPLE_AT = 8,
    parameter int MAX_BITS  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                baud_tick,
    input  logic                rxd,
    input  logic [1:0]          size_code,
    output logic                start_ok,
    output logic                char_done,
    output logic [MAX_BITS-1:0] char_data,
    output logic                char_fe
);

    localparam int CNT_W    = $clog2(OVS);
    localparam int IDX_W    = $clog2(MAX_BITS + 1);
    localparam int MIN_BITS = MAX_BITS - 3;

    rx_state_e            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [MAX_BITS-1:0]  data_q;
    logic                 sync1_q, rxd_s;
    logic                 mid_start, bit_end, last_bit;
    logic [IDX_W-1:0]     last_idx;

    // two-stage synchronizer for the asynchronous line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            rxd_s   <= 1'b1;
        end else begin
            sync1_q <= rxd;
            rxd_s   <= sync1_q;
        end
    end

    assign last_idx  = IDX_W'(MIN_BITS - 1) + IDX_W'(size_code);
    assign mid_start = (state_q == RX_START_CHECK) && baud_tick
                       && (cnt_q == CNT_W'(SAMPLE_AT - 1));
    assign bit_end   = baud_tick && (cnt_q == CNT_W'(OVS - 1));
    assign last_bit  = (idx_q == last_idx);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:
                if (baud_tick && !rxd_s) state_d = RX_START_CHECK;
            RX_START_CHECK:
                if (mid_start) state_d = rxd_s ? RX_IDLE : RX_SHIFT_DATA;
            RX_SHIFT_DATA:
                if (bit_end && last_bit) state_d = RX_STOP_CHECK;
            RX_STOP_CHECK:
                if (bit_end) state_d = RX_IDLE;
            default:
                state_d = RX_IDLE;
        endcase
        if (!enable) state_d = RX_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // counters and shift data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
        end else if (!enable) begin
            cnt_q  <= '0;
            idx_q  <= '0;
        end else if (baud_tick) begin
            unique case (state_q)
                RX_IDLE: begin
                    if (!rxd_s) cnt_q <= CNT_W'(1);
                end
                RX_START_CHECK: begin
                    if (mid_start) begin
                        cnt_q  <= '0;
                        idx_q  <= '0;
                        data_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                RX_SHIFT_DATA: begin
                    if (bit_end) begin
                        for (int b = 0; b < MAX_BITS; b++) begin
                            if (idx_q == IDX_W'(b)) data_q[b] <= rxd_s;
                        end
                        idx_q <= idx_q + IDX_W'(1);
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                RX_STOP_CHECK: begin
                    cnt_q <= bit_end ? '0 : cnt_q + CNT_W'(1);
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        start_ok  = enable && mid_start && !rxd_s;
        char_done = enable && (state_q == RX_STOP_CHECK) && bit_end;
        char_fe   = !rxd_s;
        char_data = data_q;
    end

    // R8: entering SHIFT_DATA requires a low line at the mid-bit check
    assert_start_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_SHIFT_DATA && $past(state_q) == RX_START_CHECK) |-> !$past(rxd_s));

    // R9: a disabled receiver stays idle
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == RX_IDLE));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         in_valid,
    input  logic [W-1:0]                 in_data,
    input  logic                         in_fe,
    input  logic                         start_ok,
    input  logic                         pop,
    output logic [W-1:0]                 head_data,
    output logic                         head_fe,
    output logic                         not_empty,
    output logic                         overrun,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic             hold_v_q, hold_fe_q;
    logic [W-1:0]     hold_data_q;
    logic             overrun_q;
    logic [W:0]       entry_q [DEPTH];
    logic             full, do_pop, drain, ovr_evt;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (count_q == CNT_W'(DEPTH));
    assign do_pop  = pop && (count_q != '0);
    assign drain   = hold_v_q && (!full || do_pop);
    assign ovr_evt = start_ok && hold_v_q && !drain;

    // holding stage, pointers, occupancy and overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q     <= '0;
            rd_ptr_q    <= '0;
            wr_ptr_q    <= '0;
            hold_v_q    <= 1'b0;
            hold_fe_q   <= 1'b0;
            hold_data_q <= '0;
            overrun_q   <= 1'b0;
        end else if (flush) begin
            count_q   <= '0;
            rd_ptr_q  <= '0;
            wr_ptr_q  <= '0;
            hold_v_q  <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            if (drain || ovr_evt) hold_v_q <= 1'b0;
            if (in_valid) begin
                hold_v_q    <= 1'b1;
                hold_data_q <= in_data;
                hold_fe_q   <= in_fe;
            end
            if (drain)  wr_ptr_q <= ptr_next(wr_ptr_q);
            if (do_pop) rd_ptr_q <= ptr_next(rd_ptr_q);
            count_q <= count_q + CNT_W'(drain) - CNT_W'(do_pop);
            if (ovr_evt)     overrun_q <= 1'b1;
            else if (do_pop) overrun_q <= 1'b0;
        end
    end

    // storage entries, one write enable each
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) entry_q[e] <= '0;
            else if (drain && !flush && wr_ptr_q == PTR_W'(e))
                entry_q[e] <= {hold_fe_q, hold_data_q};
        end
    end

    always_comb begin
        not_empty = (count_q != '0);
        head_data = not_empty ? entry_q[rd_ptr_q][W-1:0] : '0;
        head_fe   = not_empty && entry_q[rd_ptr_q][W];
        overrun   = overrun_q;
        count     = count_q;
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count_q == '0 && !hold_v_q && !in_valid && !flush) |=> (count_q == '0));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0 && !hold_v_q && !overrun_q));

    assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !flush) |=> (overrun_q && !hold_v_q && count_q == CNT_W'(DEPTH)));

    assert_hold_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !hold_v_q);

endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [DATA_BITS-1:0] head_data,
    input  logic                 head_fe,
    input  logic                 not_empty,
    input  logic                 overrun,
    output logic                 rx_en,
    output logic [1:0]           size_code,
    output logic                 pop,
    output logic                 irq
);

    logic [BUS_W-1:0] ctrl_q;
    logic [BUS_W-1:0] status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else if (bus_sel && bus_wr && bus_addr == ADDR_CTRL) ctrl_q <= bus_wdata;
    end

    always_comb begin
        status                 = '0;
        status[STAT_READY_BIT] = not_empty;
        status[STAT_FERR_BIT]  = head_fe;
        status[STAT_OVR_BIT]   = overrun;
        unique case (bus_addr)
            ADDR_DATA:   bus_rdata = BUS_W'(head_data);
            ADDR_STATUS: bus_rdata = status;
            ADDR_CTRL:   bus_rdata = ctrl_q;
            default:     bus_rdata = '0;
        endcase
        rx_en     = ctrl_q[CTRL_EN_BIT];
        size_code = ctrl_q[CTRL_SIZE_LO +: 2];
        pop       = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);
        irq       = not_empty && ctrl_q[CTRL_IE_BIT];
    end

    // R7: a status write leaves the control register untouched
    assert_status_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_STATUS) |=> $stable(ctrl_q));

endmodule

// File: rtl/uart_rx_fifo_top.sv
module uart_rx_fifo_top
    import uart_rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int SAMPLE_AT = 8,
    parameter int DATA_BITS = 8,
    parameter int DEPTH     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                 rx_en, pop, start_ok, char_done, char_fe;
    logic [1:0]           size_code;
    logic [DATA_BITS-1:0] char_data, head_data;
    logic                 head_fe, not_empty, overrun;
    logic [CNT_W-1:0]     fifo_count;

    uart_rx_shifter #(
        .OVS       (OVS),
        .SAMPLE_AT (SAMPLE_AT),
        .MAX_BITS  (DATA_BITS)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rx_en),
        .baud_tick (baud_tick),
        .rxd       (rxd),
        .size_code (size_code),
        .start_ok  (start_ok),
        .char_done (char_done),
        .char_data (char_data),
        .char_fe   (char_fe)
    );

    uart_rx_fifo #(
        .DEPTH (DEPTH),
        .W     (DATA_BITS)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!rx_en),
        .in_valid  (char_done),
        .in_data   (char_data),
        .in_fe     (char_fe),
        .start_ok  (start_ok),
        .pop       (pop),
        .head_data (head_data),
        .head_fe   (head_fe),
        .not_empty (not_empty),
        .overrun   (overrun),
        .count     (fifo_count)
    );

    uart_rx_regs #(
        .DATA_BITS (DATA_BITS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .head_data (head_data),
        .head_fe   (head_fe),
        .not_empty (not_empty),
        .overrun   (overrun),
        .rx_en     (rx_en),
        .size_code (size_code),
        .pop       (pop),
        .irq       (irq)
    );

    // R10: an interrupt request implies the queue holds data
    assert_irq_has_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fifo_count != '0));

endmodule

// File: tb/tb_uart_rx_fifo_top.sv
module tb_uart_rx_fifo_top;

    logic       clk = 1'b0;
    logic       rst_n, baud_tick, rxd, bus_sel, bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    uart_rx_fifo_top dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    initial begin
        baud_tick = 1'b0;
        forever begin
            @(negedge clk);
            baud_tick = ~baud_tick;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // one bit = 32 clocks = 16 ticks
    task automatic send_frame(input logic [7:0] d, input int nbits, input bit good_stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (31) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            rxd = d[i];
            repeat (31) @(negedge clk);
        end
        @(negedge clk);
        if (good_stop) begin
            rxd = 1'b1;
            repeat (31) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (19) @(negedge clk);
            rxd = 1'b1;
            repeat (12) @(negedge clk);
        end
        repeat (32) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(2'd1, v); check("R1 status", v, 8'h00);
        bus_read(2'd2, v); check("R1 ctrl", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        bus_write(2'd2, 8'h0D);
        send_frame(8'hA6, 8, 1'b1);
        bus_read(2'd1, v); check("R2 ready", v, 8'h80);
        send_frame(8'h3C, 8, 1'b1);
        bus_read(2'd0, v); check("R3 first", v, 8'hA6);
        bus_read(2'd1, v); check("R2 still ready", v, 8'h80);
        bus_read(2'd0, v); check("R3 second", v, 8'h3C);
        bus_read(2'd1, v); check("R2 empty", v, 8'h00);
    endtask

    task automatic t_sizes();
        logic [7:0] v, mask;
        for (int s = 0; s < 4; s++) begin
            bus_write(2'd2, 8'h01 | 8'(s << 2));
            send_frame(8'hB5, 5 + s, 1'b1);
            mask = 8'((1 << (5 + s)) - 1);
            bus_read(2'd0, v); check("R4 size", v, 8'hB5 & mask);
        end
        bus_write(2'd2, 8'h0D);
    endtask

    task automatic t_frame_err();
        logic [7:0] v;
        send_frame(8'h11, 8, 1'b1);
        send_frame(8'h22, 8, 1'b0);
        bus_read(2'd1, v); check("R5 head good", v, 8'h80);
        bus_read(2'd0, v); check("R5 data a", v, 8'h11);
        bus_read(2'd1, v); check("R5 head bad", v, 8'h90);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, v); check("R7 fe kept", v, 8'h90);
        bus_read(2'd0, v); check("R5 data b", v, 8'h22);
        bus_read(2'd1, v); check("R8 no false char", v, 8'h00);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        bus_read(2'd1, v); check("R8 glitch", v, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send_frame(8'h01, 8, 1'b1);
        send_frame(8'h02, 8, 1'b1);
        send_frame(8'h03, 8, 1'b1);
        send_frame(8'h04, 8, 1'b1);
        bus_read(2'd1, v); check("R6 dor set", v, 8'h88);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, v); check("R7 dor kept", v, 8'h88);
        bus_read(2'd0, v); check("R6 keep first", v, 8'h01);
        bus_read(2'd1, v); check("R6 dor cleared", v, 8'h80);
        bus_read(2'd0, v); check("R6 keep second", v, 8'h02);
        bus_read(2'd0, v); check("R6 third lost", v, 8'h04);
        bus_read(2'd1, v); check("R6 empty", v, 8'h00);
    endtask

    task automatic t_hold_drain();
        logic [7:0] v;
        send_frame(8'h51, 8, 1'b1);
        send_frame(8'h52, 8, 1'b1);
        send_frame(8'h53, 8, 1'b1);
        bus_read(2'd0, v); check("R11 first", v, 8'h51);
        bus_read(2'd0, v); check("R11 second", v, 8'h52);
        bus_read(2'd1, v); check("R11 no dor", v, 8'h80);
        bus_read(2'd0, v); check("R11 held", v, 8'h53);
        bus_read(2'd1, v); check("R11 empty", v, 8'h00);
    endtask

    task automatic t_flush();
        logic [7:0] v;
        send_frame(8'h61, 8, 1'b1);
        send_frame(8'h62, 8, 1'b1);
        send_frame(8'h63, 8, 1'b1);
        bus_write(2'd2, 8'h0C);
        bus_read(2'd1, v); check("R9 flushed", v, 8'h00);
        send_frame(8'h64, 8, 1'b1);
        bus_read(2'd1, v); check("R9 disabled ignores", v, 8'h00);
        bus_write(2'd2, 8'h0D);
        bus_read(2'd1, v); check("R9 reenable empty", v, 8'h00);
        send_frame(8'h65, 8, 1'b1);
        bus_read(2'd0, v); check("R9 fresh data", v, 8'h65);
        bus_read(2'd1, v); check("R9 no stale", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        send_frame(8'h77, 8, 1'b1);
        check("R10 masked", {7'd0, irq}, 8'h00);
        bus_write(2'd2, 8'h0F);
        check("R10 raised", {7'd0, irq}, 8'h01);
        bus_read(2'd0, v); check("R10 data", v, 8'h77);
        check("R10 dropped", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rxd = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = 2'd0; bus_wdata = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_sizes();
        t_frame_err();
        t_glitch();
        t_overrun();
        t_hold_drain();
        t_flush();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule